// File: doc/BRIEF.md
# Hitless Phase-Offset Mode Controller

This block sets the operating mode of a digital clock synchronizer. There are three modes: Normal, where the loop tracks a reference; Holdover; and Freerun. The block also manages a stored phase offset, which is a count of local clock cycles from an edge of the selected reference to the next local output edge. The loop adds this offset to its output so that a change of mode or a change of reference does not step the output phase. A 2-bit select either forces one of the three modes or leaves the choice to the block. In the automatic setting the block drops into Holdover when the selected reference fails, and returns to Normal once that reference is valid again.

On a return to Normal on the same reference, the hitless control input decides what happens to the stored offset. When it is low, the stored offset is kept. When it is high, a new offset is measured. Selecting a different reference always starts a new measurement. A clear input sets the stored offset to zero. The block drives the Holdover flag and a lock flag. The lock flag is the loop's lock report, qualified by Normal mode.

Top module: `hitless_mode_ctrl`

## Requirements
- R1: After reset the block is in Freerun (`mode_out` = 2'b10), `offset` is 0, and `holdover`, `locked` and `meas_done` are low.
- R2: `mode_out` encodes the mode as 2'b00 Normal, 2'b01 Holdover and 2'b10 Freerun. A `mode_sel` of 2'b01, 2'b10 or 2'b11 forces Normal, Holdover or Freerun respectively from the next clock edge, whatever the reference failure flags show.
- R3: `holdover` is high exactly while `mode_out` shows Holdover.
- R4: `locked` is high only while the mode is Normal and `loop_locked` is high.
- R5: With `mode_sel` = 2'b00, the selected reference is failed when `ref_fail[ref_sel]` is high or when `ref_sel` is 3. In that case Normal moves to Holdover on the next edge, while Holdover and Freerun keep their mode. When the selected reference is not failed, the mode becomes Normal on the next edge.
- R6: On a return to Normal on the same reference as the last Normal period, with `hitless_en` low, no measurement starts and `offset` keeps its value. The first Normal period after reset counts as reference 0.
- R7: On a return to Normal with `hitless_en` high, a measurement starts. If `ref_edge` is sampled high at edge k and `out_edge` is next sampled high at edge k+n, then after edge k+n `offset` equals n and `meas_done` is high for exactly that one cycle.
- R8: A change of `ref_sel` that enters Normal or stays in Normal starts a measurement, whatever the value of `hitless_en`.
- R9: The measured count saturates at 2^CW-1, which is 65535 with the default CW of 16.
- R10: `offset_clr` sampled high makes `offset` 0 after that edge and cancels any measurement in progress.
- R11: A measurement in progress is abandoned when the block leaves Normal, and `meas_done` is only ever high in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 automatic, 01 force Normal, 10 force Holdover, 11 force Freerun |
| ref_sel | input | 2 | Index of the selected reference (0 to 2) |
| ref_fail | input | 3 | Per-reference failure flags |
| hitless_en | input | 1 | High: re-measure the offset on a return to Normal |
| offset_clr | input | 1 | Clear the stored offset |
| loop_locked | input | 1 | Frequency-lock report from the loop |
| ref_edge | input | 1 | One-cycle pulse on a selected-reference edge |
| out_edge | input | 1 | One-cycle pulse on a local output edge |
| mode_out | output | 2 | Current mode (00 Normal, 01 Holdover, 10 Freerun) |
| holdover | output | 1 | High in Holdover |
| locked | output | 1 | Lock flag, qualified by Normal |
| offset | output | 16 | Stored phase offset in clock cycles |
| meas_done | output | 1 | One-cycle strobe when the offset is updated |

## Verification
The mode logic is driven by a table of select, failure and lock patterns. The table tells forced modes apart from automatic fallback and recovery, and it shows that Holdover and Freerun each keep their mode while the reference stays failed. Returns to Normal are then tried with the hitless control low and with it high, to separate keeping the offset from re-measuring it. Further cases cover a change of reference with the hitless control low, a gap long enough to saturate the counter, and a clear or a mode exit in the middle of a measurement. These last cases show that the pending result is dropped and not stored.

// File: rtl/hitless_mode_ctrl.sv
module hitless_mode_ctrl #(
  parameter int CW   = 16,
  parameter int NREF = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_sel,
  input  logic [$clog2(NREF)-1:0] ref_sel,
  input  logic [NREF-1:0]         ref_fail,
  input  logic                    hitless_en,
  input  logic                    offset_clr,
  input  logic                    loop_locked,
  input  logic                    ref_edge,
  input  logic                    out_edge,
  output logic [1:0]              mode_out,
  output logic                    holdover,
  output logic                    locked,
  output logic [CW-1:0]           offset,
  output logic                    meas_done
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam int RW = $clog2(NREF);

  typedef enum logic [1:0] {M_NORM = 2'b00, M_HOLD = 2'b01, M_FREE = 2'b10} mode_t;
  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_CNT} ph_t;

  mode_t          st, nxt;
  ph_t            ph;
  logic [RW-1:0]  ref_q;
  logic [CW-1:0]  cnt;
  logic           sel_fail, start;

  assign sel_fail = (int'(ref_sel) >= NREF) ? 1'b1 : ref_fail[ref_sel];
  assign mode_out = st;
  assign holdover = (st == M_HOLD);
  assign locked   = (st == M_NORM) && loop_locked;
  assign start    = (nxt == M_NORM) && ((ref_sel != ref_q) || ((st != M_NORM) && hitless_en));

  always_comb begin
    case (mode_sel)
      2'b01:   nxt = M_NORM;
      2'b10:   nxt = M_HOLD;
      2'b11:   nxt = M_FREE;
      default: nxt = !sel_fail ? M_NORM : ((st == M_NORM) ? M_HOLD : st);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= M_FREE;
      ph        <= P_IDLE;
      ref_q     <= '0;
      cnt       <= '0;
      offset    <= '0;
      meas_done <= 1'b0;
    end else begin
      st        <= nxt;
      meas_done <= 1'b0;
      if (nxt == M_NORM) ref_q <= ref_sel;
      if (offset_clr) begin
        offset <= '0;
        ph     <= P_IDLE;
      end else if (nxt != M_NORM) begin
        ph <= P_IDLE;
      end else if (start) begin
        ph <= P_WAIT;
      end else begin
        case (ph)
          P_WAIT: if (ref_edge) begin
            cnt <= CW'(1);
            ph  <= P_CNT;
          end
          P_CNT: if (out_edge) begin
            offset    <= cnt;
            meas_done <= 1'b1;
            ph        <= P_IDLE;
          end else if (cnt != CMAX) begin
            cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_AUTO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && st == M_NORM && sel_fail) |=> holdover); // R5
  AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == P_IDLE && !offset_clr) |=> $stable(offset)); // R6
  AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> $past(out_edge)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    offset_clr |=> (offset == '0 && !meas_done)); // R10
  AST_DONE_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> (mode_out == 2'b00)); // R11
endmodule

// File: tb/hitless_mode_ctrl_tb.sv
module hitless_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b11;
  logic [1:0] ref_sel = 2'b00;
  logic [2:0] ref_fail = 3'b000;
  logic hitless_en = 1'b0, offset_clr = 1'b0, loop_locked = 1'b0;
  logic ref_edge = 1'b0, out_edge = 1'b0;
  logic [1:0] mode_out;
  logic holdover, locked, meas_done;
  logic [15:0] offset;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hitless_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_sel(ref_sel),
    .ref_fail(ref_fail), .hitless_en(hitless_en), .offset_clr(offset_clr),
    .loop_locked(loop_locked), .ref_edge(ref_edge), .out_edge(out_edge),
    .mode_out(mode_out), .holdover(holdover), .locked(locked),
    .offset(offset), .meas_done(meas_done)
  );

  // vector: mode_sel[9:8] ref_fail[7:5] loop_locked[4] exp_mode[3:2] exp_hold[1] exp_lock[0]
  localparam logic [9:0] VEC [12] = '{
    {2'b01, 3'b000, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'b01, 3'b001, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'b10, 3'b000, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'b11, 3'b000, 1'b1, 2'b10, 1'b0, 1'b0},
    {2'b00, 3'b000, 1'b0, 2'b00, 1'b0, 1'b0},
    {2'b00, 3'b000, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'b00, 3'b001, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'b00, 3'b001, 1'b1, 2'b01, 1'b1, 1'b0},
    {2'b00, 3'b110, 1'b1, 2'b00, 1'b0, 1'b1},
    {2'b11, 3'b000, 1'b1, 2'b10, 1'b0, 1'b0},
    {2'b00, 3'b001, 1'b0, 2'b10, 1'b0, 1'b0},
    {2'b00, 3'b000, 1'b1, 2'b00, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int n);
    ref_edge = 1'b1;
    @(negedge clk) ref_edge = 1'b0;
    repeat (n - 1) @(negedge clk);
    out_edge = 1'b1;
    @(negedge clk) out_edge = 1'b0;
  endtask

  task automatic reenter(input logic hl, input logic [1:0] away);
    mode_sel = away;
    @(negedge clk);
    hitless_en = hl;
    mode_sel = 2'b01;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", mode_out, 2);
    chk("R1 offset", offset, 0);
    chk("R1 flags", {holdover, locked, meas_done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      mode_sel = VEC[i][9:8];
      ref_fail = VEC[i][7:5];
      loop_locked = VEC[i][4];
      @(negedge clk);
      chk($sformatf("R2/R5 mode v%0d", i), mode_out, VEC[i][3:2]);
      chk($sformatf("R3 holdover v%0d", i), holdover, VEC[i][1]);
      chk($sformatf("R4 locked v%0d", i), locked, VEC[i][0]);
      chk($sformatf("R6 offset v%0d", i), offset, 0);
    end
    ref_fail = 3'b000;

    reenter(1'b1, 2'b11);
    chk("R7 normal", mode_out, 0);
    measure(5);
    chk("R7 offset", offset, 5);
    chk("R7 done", meas_done, 1);
    @(negedge clk);
    chk("R7 pulse", meas_done, 0);

    reenter(1'b0, 2'b11);
    measure(9);
    chk("R6 kept", offset, 5);
    chk("R6 no done", meas_done, 0);

    ref_sel = 2'b01;
    @(negedge clk);
    measure(3);
    chk("R8 offset", offset, 3);
    chk("R8 done", meas_done, 1);

    reenter(1'b1, 2'b10);
    measure(70000);
    chk("R9 saturate", offset, 65535);

    offset_clr = 1'b1;
    @(negedge clk) offset_clr = 1'b0;
    chk("R10 clear", offset, 0);

    reenter(1'b1, 2'b11);
    ref_edge = 1'b1;
    @(negedge clk) ref_edge = 1'b0;
    offset_clr = 1'b1;
    @(negedge clk) offset_clr = 1'b0;
    out_edge = 1'b1;
    @(negedge clk) out_edge = 1'b0;
    chk("R10 cancel offset", offset, 0);
    chk("R10 cancel done", meas_done, 0);

    reenter(1'b1, 2'b11);
    ref_edge = 1'b1;
    @(negedge clk) ref_edge = 1'b0;
    mode_sel = 2'b10;
    @(negedge clk);
    chk("R11 holdover", mode_out, 1);
    hitless_en = 1'b0;
    mode_sel = 2'b01;
    @(negedge clk);
    out_edge = 1'b1;
    @(negedge clk) out_edge = 1'b0;
    chk("R11 abort offset", offset, 0);
    chk("R11 abort done", meas_done, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule